// File: doc/BRIEF.md
# DMA Channel Request State Tracker

This block holds the per-channel request bookkeeping of a multi-channel DMA controller. For each channel it keeps a pending bit, a busy bit and a suspend flag. From these it derives an eligibility vector, which lists the channels the external arbiter may choose from. Its inputs are the per-channel enable level, suspend and resume pulses, and transfer triggers. It also receives two single-channel strobes: a handoff strobe, sent when a channel's descriptor moves from the prefetch stage into the active stage, and a burst-complete strobe, which carries a 2-bit code for what the channel does next.

Suspending and disabling are kept distinct. A suspended channel drops out of the eligibility vector but keeps its pending bit, so a later resume puts it back in contention. A disabled channel loses its pending, busy and suspend state outright.

All state sits in registers and changes on the rising clock edge. Eligibility is a combinational function of that registered state. Descriptor fetch, memory access, the burst data path and the arbitration choice itself belong to other blocks.

Top module: `dma_chan_tracker`

## Requirements
- R1: A synchronous active-high reset clears pending, busy, suspend and eligibility for every channel at the next edge.
- R2: A trigger on an enabled channel whose suspend flag is clear sets its pending bit at the next edge. The channel is then eligible, and this holds even if its handoff strobe arrives in the same cycle.
- R3: A trigger on a channel that is disabled (enable low) or has its suspend flag set is ignored, and its pending bit keeps its value.
- R4: A handoff strobe naming channel c clears pending for c at the next edge, unless c is triggered in that cycle. If the first-burst input is 1, busy for c is set.
- R5: A handoff with the first-burst input at 0 leaves a busy bit that is already 1 at 1.
- R6: Burst-complete with code 0 (requeue) sets pending for the channel and leaves busy at 1.
- R7: Burst-complete with code 1 (wait for trigger) clears busy and leaves pending unchanged.
- R8: Burst-complete with code 2 (suspend) clears busy and sets the suspend flag.
- R9: Burst-complete with code 3 (disable) clears both busy and pending.
- R10: A suspend pulse on an enabled channel sets its suspend flag and removes it from eligibility while pending stays as it was. A suspend pulse wins over a resume pulse in the same cycle.
- R11: A resume pulse clears the suspend flag. A channel that is still pending then becomes eligible again.
- R12: A channel whose enable is low has pending, busy and suspend cleared at the next edge and is never eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | NUM_CH | Per-channel enable level |
| trig_i | input | NUM_CH | Per-channel transfer trigger pulse |
| susp_req_i | input | NUM_CH | Per-channel suspend pulse |
| resume_i | input | NUM_CH | Per-channel resume pulse |
| handoff_vld_i | input | 1 | Descriptor moved from prefetch to active |
| handoff_ch_i | input | CHW | Channel of the handoff |
| handoff_first_i | input | 1 | Handoff starts the first burst of a request |
| done_vld_i | input | 1 | Granted burst finished |
| done_ch_i | input | CHW | Channel whose burst finished |
| done_outcome_i | input | 2 | Next-state code: 0 requeue, 1 wait, 2 suspend, 3 disable |
| pending_o | output | NUM_CH | Pending bits |
| busy_o | output | NUM_CH | Busy bits |
| susp_o | output | NUM_CH | Suspend flags |
| elig_o | output | NUM_CH | Channels eligible for arbitration |

## Verification
A vector table takes two channels through a whole request cycle: trigger, first handoff, requeue, later handoff and each of the four completion codes. This separates the cases where busy must be held from those where it must be dropped. Triggers sent to suspended and disabled channels show whether a trigger is gated by the suspend flag, by the enable level, or by both. A suspend followed by a resume on a pending channel shows whether the pending bit survives while eligibility drops. Directed cases cover a trigger in the same cycle as its own channel's handoff, suspend and resume pulses together, and a reset issued in mid-run.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    OC_REQUEUE = 2'd0,
    OC_WAIT    = 2'd1,
    OC_SUSPEND = 2'd2,
    OC_DISABLE = 2'd3
  } outcome_e;

  typedef struct packed {
    logic pend;
    logic busy;
    logic susp;
  } chan_st_t;

  typedef struct packed {
    logic     en;
    logic     trig;
    logic     sreq;
    logic     resume;
    logic     hand;
    logic     first;
    logic     done;
    outcome_e oc;
  } chan_ev_t;

  // Next state of one channel. The steps are applied in a fixed order,
  // so a later step wins over an earlier one.
  function automatic chan_st_t chan_next(chan_st_t cur, chan_ev_t ev);
    chan_st_t nx;
    nx = cur;
    if (ev.done) begin
      unique case (ev.oc)
        OC_REQUEUE: nx.pend = 1'b1;
        OC_WAIT:    nx.busy = 1'b0;
        OC_SUSPEND: nx.busy = 1'b0;
        OC_DISABLE: begin
          nx.busy = 1'b0;
          nx.pend = 1'b0;
        end
        default: nx = cur;
      endcase
    end
    if (ev.hand) begin
      nx.pend = 1'b0;
      if (ev.first) nx.busy = 1'b1;
    end
    if (ev.trig && !cur.susp) nx.pend = 1'b1;
    if (ev.resume) nx.susp = 1'b0;
    if (ev.sreq) nx.susp = 1'b1;
    if (ev.done && ev.oc == OC_SUSPEND) nx.susp = 1'b1;
    if (!ev.en) nx = '0;
    return nx;
  endfunction

  function automatic logic chan_elig(chan_st_t s);
    return s.pend & ~s.susp;
  endfunction

endpackage

// File: rtl/dct_onehot.sv
module dct_onehot #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         vld,
  input  logic [W-1:0] idx,
  output logic [N-1:0] vec
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec[i] = vld && (idx == W'(i));
  end
endmodule

// File: rtl/dct_chan.sv
module dct_chan
  import dct_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  chan_ev_t ev,
  output chan_st_t st,
  output logic     elig
);
  chan_st_t st_q;
  chan_st_t st_d;

  always_comb st_d = chan_next(st_q, ev);

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign st   = st_q;
  assign elig = chan_elig(st_q);
endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
  import dct_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic [NUM_CH-1:0] susp_req_i,
  input  logic [NUM_CH-1:0] resume_i,
  input  logic              handoff_vld_i,
  input  logic [CHW-1:0]    handoff_ch_i,
  input  logic              handoff_first_i,
  input  logic              done_vld_i,
  input  logic [CHW-1:0]    done_ch_i,
  input  logic [1:0]        done_outcome_i,
  output logic [NUM_CH-1:0] pending_o,
  output logic [NUM_CH-1:0] busy_o,
  output logic [NUM_CH-1:0] susp_o,
  output logic [NUM_CH-1:0] elig_o
);
  // Named per-channel event wires, also read by the checker.
  logic [NUM_CH-1:0] hand_vec;
  logic [NUM_CH-1:0] done_vec;

  dct_onehot #(.N(NUM_CH)) u_hand_dec (
    .vld(handoff_vld_i), .idx(handoff_ch_i), .vec(hand_vec)
  );
  dct_onehot #(.N(NUM_CH)) u_done_dec (
    .vld(done_vld_i), .idx(done_ch_i), .vec(done_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_ev_t ev;
    chan_st_t st;
    always_comb begin
      ev.en     = en_i[c];
      ev.trig   = trig_i[c];
      ev.sreq   = susp_req_i[c];
      ev.resume = resume_i[c];
      ev.hand   = hand_vec[c];
      ev.first  = handoff_first_i;
      ev.done   = done_vec[c];
      ev.oc     = outcome_e'(done_outcome_i);
    end
    dct_chan u_chan (
      .clk(clk), .rst(rst), .ev(ev), .st(st), .elig(elig_o[c])
    );
    assign pending_o[c] = st.pend;
    assign busy_o[c]    = st.busy;
    assign susp_o[c]    = st.susp;
  end
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] trig_i,
  input logic [NUM_CH-1:0] susp_req_i,
  input logic [NUM_CH-1:0] resume_i,
  input logic              handoff_first_i,
  input logic [1:0]        done_outcome_i,
  input logic [NUM_CH-1:0] hand_vec,
  input logic [NUM_CH-1:0] done_vec,
  input logic [NUM_CH-1:0] pending_o,
  input logic [NUM_CH-1:0] busy_o,
  input logic [NUM_CH-1:0] susp_o,
  input logic [NUM_CH-1:0] elig_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pending_o == '0 && busy_o == '0 && susp_o == '0 && elig_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R2
    trig_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && trig_i[c] && !susp_o[c] |=> pending_o[c]);
    // R3
    trig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && trig_i[c] && susp_o[c] && !hand_vec[c] && !done_vec[c]
      |=> $stable(pending_o[c]));
    // R4
    hand_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && hand_vec[c] && !trig_i[c] |=> !pending_o[c]);
    // R4
    hand_first_busy_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && hand_vec[c] && handoff_first_i |=> busy_o[c]);
    // R5
    hand_later_busy_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && hand_vec[c] && !handoff_first_i && busy_o[c] && !done_vec[c]
      |=> busy_o[c]);
    // R6
    done_requeue_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && done_vec[c] && done_outcome_i == 2'd0 && !hand_vec[c]
      |=> pending_o[c]);
    // R7
    done_wait_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && done_vec[c] && done_outcome_i == 2'd1 && !hand_vec[c] && !trig_i[c]
      |=> !busy_o[c] && $stable(pending_o[c]));
    // R8
    done_susp_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && done_vec[c] && done_outcome_i == 2'd2 && !hand_vec[c]
      |=> susp_o[c] && !busy_o[c]);
    // R9
    done_disable_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && done_vec[c] && done_outcome_i == 2'd3 && !hand_vec[c] && !trig_i[c]
      |=> !busy_o[c] && !pending_o[c]);
    // R10
    susp_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && susp_req_i[c] && !trig_i[c] && !hand_vec[c] && !done_vec[c]
      |=> susp_o[c] && !elig_o[c] && $stable(pending_o[c]));
    // R11
    resume_clears_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[c] && resume_i[c] && !susp_req_i[c] && !done_vec[c]
      |=> !susp_o[c]);
    // R12
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
      !en_i[c] |=> !pending_o[c] && !busy_o[c] && !susp_o[c] && !elig_o[c]);
  end
endmodule

bind dma_chan_tracker dct_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/dma_chan_tracker_tb.sv
module dma_chan_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst;
  logic [7:0] en, trig, sreq, res;
  logic hv, hf, dv;
  logic [2:0] hch, dch;
  logic [1:0] doc;
  logic [7:0] pend, busy, susp, elig;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_tracker #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .trig_i(trig), .susp_req_i(sreq),
    .resume_i(res), .handoff_vld_i(hv), .handoff_ch_i(hch),
    .handoff_first_i(hf), .done_vld_i(dv), .done_ch_i(dch),
    .done_outcome_i(doc), .pending_o(pend), .busy_o(busy),
    .susp_o(susp), .elig_o(elig)
  );

  typedef struct packed {
    logic [7:0] en, trig, sreq, res;
    logic hv; logic [2:0] hch; logic hf;
    logic dv; logic [2:0] dch; logic [1:0] doc;
    logic [7:0] ep, eb, es;
  } vec_t;

  localparam int NV = 19;
  // en trig sreq res | hv hch hf | dv dch doc | expected pend busy susp
  localparam vec_t VEC [NV] = '{
    '{8'hFF,8'h03,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h03,8'h00,8'h00}, // R2
    '{8'hFF,8'h00,8'h00,8'h00, 1'b1,3'd0,1'b1, 1'b0,3'd0,2'd0, 8'h02,8'h01,8'h00}, // R4
    '{8'hFF,8'h00,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b1,3'd0,2'd0, 8'h03,8'h01,8'h00}, // R6
    '{8'hFF,8'h00,8'h00,8'h00, 1'b1,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h02,8'h01,8'h00}, // R5
    '{8'hFF,8'h00,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b1,3'd0,2'd1, 8'h02,8'h00,8'h00}, // R7
    '{8'hFF,8'h00,8'h02,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h02,8'h00,8'h02}, // R10
    '{8'hFF,8'h02,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h02,8'h00,8'h02}, // R3
    '{8'hFF,8'h00,8'h00,8'h02, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h02,8'h00,8'h00}, // R11
    '{8'hFF,8'h00,8'h00,8'h00, 1'b1,3'd1,1'b1, 1'b0,3'd0,2'd0, 8'h00,8'h02,8'h00}, // R4
    '{8'hFF,8'h00,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b1,3'd1,2'd2, 8'h00,8'h00,8'h02}, // R8
    '{8'hFF,8'h04,8'h00,8'h02, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h04,8'h00,8'h00}, // R11
    '{8'hFF,8'h00,8'h00,8'h00, 1'b1,3'd2,1'b1, 1'b0,3'd0,2'd0, 8'h00,8'h04,8'h00}, // R4
    '{8'hFF,8'h04,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h04,8'h04,8'h00}, // R2
    '{8'hFF,8'h00,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b1,3'd2,2'd3, 8'h00,8'h00,8'h00}, // R9
    '{8'hFF,8'hA0,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'hA0,8'h00,8'h00}, // R2
    '{8'h7F,8'h80,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h20,8'h00,8'h00}, // R12
    '{8'h7F,8'h80,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h20,8'h00,8'h00}, // R3
    '{8'hFF,8'h00,8'h20,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h20,8'h00,8'h20}, // R10
    '{8'hDF,8'h00,8'h00,8'h00, 1'b0,3'd0,1'b0, 1'b0,3'd0,2'd0, 8'h00,8'h00,8'h00}  // R12
  };

  function automatic string req_of(int i);
    case (i)
      0, 12, 14: return "R2";
      1, 8, 11:  return "R4";
      2:         return "R6";
      3:         return "R5";
      4:         return "R7";
      5, 17:     return "R10";
      6, 16:     return "R3";
      7, 10:     return "R11";
      9:         return "R8";
      13:        return "R9";
      default:   return "R12";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    trig = '0; sreq = '0; res = '0;
    hv = 1'b0; hch = '0; hf = 1'b0;
    dv = 1'b0; dch = '0; doc = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; en = 8'hFF; idle();
    step(); step();
    // R1: reset state
    chk("R1", "pending", pend, 8'h00);
    chk("R1", "busy", busy, 8'h00);
    chk("R1", "susp", susp, 8'h00);
    chk("R1", "elig", elig, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      en = VEC[i].en; trig = VEC[i].trig; sreq = VEC[i].sreq; res = VEC[i].res;
      hv = VEC[i].hv; hch = VEC[i].hch; hf = VEC[i].hf;
      dv = VEC[i].dv; dch = VEC[i].dch; doc = VEC[i].doc;
      step();
      chk(req_of(i), "pending", pend, VEC[i].ep);
      chk(req_of(i), "busy", busy, VEC[i].eb);
      chk(req_of(i), "susp", susp, VEC[i].es);
      chk(req_of(i), "elig", elig, VEC[i].ep & ~VEC[i].es);
    end

    // R2 with R4: trigger in the same cycle as the channel's own handoff
    en = 8'hFF; idle(); trig = 8'h08; step();
    trig = 8'h08; hv = 1'b1; hch = 3'd3; hf = 1'b1; step();
    chk("R2", "pending trig+handoff", pend, 8'h08);
    chk("R4", "busy trig+handoff", busy, 8'h08);

    // R10: suspend and resume together, suspend wins
    idle(); sreq = 8'h08; res = 8'h08; step();
    chk("R10", "susp both pulses", susp, 8'h08);
    chk("R10", "elig both pulses", elig, 8'h00);

    // R11: resume makes the still-pending channel eligible again
    idle(); res = 8'h08; step();
    chk("R11", "elig after resume", elig, 8'h08);

    // R1: reset in mid-run clears held state
    idle(); sreq = 8'h08; step();
    idle(); rst = 1'b1; step();
    chk("R1", "pending mid reset", pend, 8'h00);
    chk("R1", "busy mid reset", busy, 8'h00);
    chk("R1", "susp mid reset", susp, 8'h00);
    rst = 1'b0; step();

    finish_run();
  end
endmodule